// File: doc/BRIEF.md
# Sub-Code Corrector for a Three-Stage Pipelined Converter

This block sits behind the analog front end of a three-stage pipelined analog-to-digital converter. Each conversion step produces a small raw code: the two coarse stages give 3 bits each and the fine stage gives 4 bits. The stages settle one after another, so the three codes that belong to one sample reach the block on three consecutive clocks. The block holds the earlier codes back until the last one arrives. It then adds the three codes with overlapping weights, subtracts a centring offset, limits the result to the 8-bit range and registers it into an output latch.

One corrected word leaves the block every clock, with a fixed latency from the first code of a sample to its word on the bus. The output bus is modelled as a data vector plus a drive-enable flag, so the three-state pad can sit outside the core. A valid flag tells downstream logic when the pipeline has filled after reset.

Top module: `subcode_corrector`

## Requirements
- R1: Whenever `rst_n` is low, `dout` reads 0 and `dout_valid` reads 0 without waiting for a clock edge.
- R2: For one sample, `st1_code` is presented at rising edge k, `st2_code` at edge k+1 and `st3_code` at edge k+2. The block combines only codes that belong to the same sample.
- R3: The corrected word is st1*32 + st2*8 + st3 - 20, limited to the range 0..255.
- R4: A sum above 255 after the offset gives 255. For example (7,6,3) gives exactly 255 and (7,6,4) is limited to 255.
- R5: A sum below 0 after the offset gives 0. For example (0,2,3) is limited to 0 and (0,2,5) gives 1.
- R6: The word for a sample whose stage-one code is captured at edge k is on `dout` after edge k+3. A new word follows on every edge.
- R7: After reset is released, `dout_valid` stays 0 for the first three rising edges. It goes to 1 on the fourth edge and stays 1 until the next reset.
- R8: `dout_drive` is 1 exactly when `oe_n` is 0. `oe_n` has no effect on the values carried by `dout`.
- R9: Mid-scale code 128 is reached by the triple (4,2,4). The redundant triple (3,6,4) gives the same code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| oe_n | input | 1 | Active-low output enable |
| st1_code | input | 3 | First coarse stage code |
| st2_code | input | 3 | Second coarse stage code, one clock behind stage one |
| st3_code | input | 4 | Fine stage code, two clocks behind stage one |
| dout | output | 8 | Corrected sample from the output latch |
| dout_drive | output | 1 | Drive enable for the external three-state pad |
| dout_valid | output | 1 | High once the pipeline holds a full sample |

## Verification
A sample's stage-one code is driven before edge k, its stage-two code before edge k+1 and its stage-three code before edge k+2. Its corrected word is due after edge k+3, so the bench compares the word read on the falling edge after edge k+3 with the model's value for that sample. The three codes of one sample are offset on the inputs in the same way, so a wrong alignment would mix neighbouring samples. The drive-enable flag is combinational and is checked in the same half cycle in which `oe_n` changes. The valid flag is counted edge by edge after reset release.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int C1_W  = 3;
  localparam int C2_W  = 3;
  localparam int C3_W  = 4;
  localparam int OUT_W = 8;

  typedef struct packed {
    logic [C1_W-1:0] c1;
    logic [C2_W-1:0] c2;
    logic [C3_W-1:0] c3;
  } triple_t;
endpackage

// File: rtl/sc_delay.sv
module sc_delay #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        din,
  output logic [D-1:0][W-1:0] taps
);
  logic [D-1:0][W-1:0] q_r;
  logic [D-1:0][W-1:0] q_nx;

  for (genvar g = 0; g < D; g++) begin : g_stg
    if (g == 0) begin : g_head
      assign q_nx[g] = din;
    end else begin : g_body
      assign q_nx[g] = q_r[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nx;
  end

  assign taps = q_r;
endmodule

// File: rtl/sc_merge.sv
module sc_merge
  import sc_pkg::*;
#(
  parameter int SH1 = 5,
  parameter int SH2 = 3,
  parameter int OFF = 20
) (
  input  triple_t          t,
  output logic [OUT_W-1:0] code
);
  localparam int CODE_MAX = (1 << OUT_W) - 1;

  logic signed [31:0] raw;

  always_comb begin
    raw = ($signed(32'(t.c1)) <<< SH1)
        + ($signed(32'(t.c2)) <<< SH2)
        +  $signed(32'(t.c3))
        - OFF;
    if (raw < 0)             code = '0;
    else if (raw > CODE_MAX) code = '1;
    else                     code = raw[OUT_W-1:0];
  end
endmodule

// File: rtl/sc_outreg.sv
module sc_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         drv_en
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nx;

  always_comb q_nx = d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nx;
  end

  assign q      = q_r;
  assign drv_en = ~oe_n;
endmodule

// File: rtl/subcode_corrector.sv
module subcode_corrector
  import sc_pkg::*;
#(
  parameter int SH1    = 5,
  parameter int SH2    = 3,
  parameter int OFFSET = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic [C1_W-1:0]  st1_code,
  input  logic [C2_W-1:0]  st2_code,
  input  logic [C3_W-1:0]  st3_code,
  output logic [OUT_W-1:0] dout,
  output logic             dout_drive,
  output logic             dout_valid
);
  localparam int D1    = 2;
  localparam int D2    = D1 - 1;
  localparam int LAT   = D1 + 2;
  localparam int TRI_W = $bits(triple_t);

  logic [D1-1:0][C1_W-1:0] a1_taps;
  logic [D2-1:0][C2_W-1:0] a2_taps;
  logic [0:0][TRI_W-1:0]   trip_q;
  logic [LAT-1:0][0:0]     fill;
  triple_t                 trip_in;
  triple_t                 trip;
  logic [OUT_W-1:0]        merged;

  sc_delay #(.W(C1_W), .D(D1)) u_d1 (
    .clk(clk), .rst_n(rst_n), .din(st1_code), .taps(a1_taps));

  sc_delay #(.W(C2_W), .D(D2)) u_d2 (
    .clk(clk), .rst_n(rst_n), .din(st2_code), .taps(a2_taps));

  always_comb begin
    trip_in.c1 = a1_taps[D1-1];
    trip_in.c2 = a2_taps[D2-1];
    trip_in.c3 = st3_code;
  end

  sc_delay #(.W(TRI_W), .D(1)) u_trip (
    .clk(clk), .rst_n(rst_n), .din(trip_in), .taps(trip_q));

  assign trip = triple_t'(trip_q[0]);

  sc_merge #(.SH1(SH1), .SH2(SH2), .OFF(OFFSET)) u_merge (
    .t(trip), .code(merged));

  sc_outreg #(.W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .d(merged),
    .q(dout), .drv_en(dout_drive));

  sc_delay #(.W(1), .D(LAT)) u_fill (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .taps(fill));

  assign dout_valid = fill[LAT-1][0];

  // R2
  align1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill[1][0] |-> (a1_taps[D1-1] == $past(st1_code, 2)));

  // R2
  align2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill[0][0] |-> (a2_taps[D2-1] == $past(st2_code, 1)));

  // R4
  clamp_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill[2][0] && trip.c1 == '1 && trip.c2 == '1) |=> (dout == '1));

  // R5
  clamp_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill[2][0] && trip.c1 == '0 && trip.c2 == '0 && int'(trip.c3) <= OFFSET)
      |=> (dout == '0));

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |=> dout_valid);
endmodule

// File: tb/test_subcode_corrector.sv
module test_subcode_corrector;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       oe_n;
  logic [2:0] s1;
  logic [2:0] s2;
  logic [3:0] s3;
  logic [7:0] dout;
  logic       drv;
  logic       vld;

  int checks = 0;
  int fails  = 0;
  int a1 [64];
  int a2 [64];
  int a3 [64];

  always #4 clk = ~clk;

  subcode_corrector i_subcode_corrector (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n),
    .st1_code(s1), .st2_code(s2), .st3_code(s3),
    .dout(dout), .dout_drive(drv), .dout_valid(vld));

  function automatic int model(int x, int y, int z);
    int r = x * 32 + y * 8 + z - 20;
    if (r < 0)   r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Staggered drive: sample j stage 1 at step j, stage 2 at j+1, stage 3 at j+2.
  task automatic run(int n, string req, bit wiggle);
    for (int i = 0; i < n + 3; i++) begin
      s1 = (i < n) ? 3'(a1[i]) : 3'd0;
      s2 = (i >= 1 && i <= n) ? 3'(a2[i-1]) : 3'd0;
      s3 = (i >= 2 && i <= n + 1) ? 4'(a3[i-2]) : 4'd0;
      if (wiggle) oe_n = (i % 2 == 1);
      @(posedge clk);
      @(negedge clk);
      if (i >= 3) chk(req, int'(dout), model(a1[i-3], a2[i-3], a3[i-3]));
      if (wiggle) chk("R8 drive", int'(drv), int'(!oe_n));
    end
    oe_n = 1'b0;
  endtask

  task automatic set3(int k, int x, int y, int z);
    a1[k] = x; a2[k] = y; a3[k] = z;
  endtask

  task automatic t_reset_fill;
    rst_n = 1'b0; s1 = '0; s2 = '0; s3 = '0;
    #1;
    chk("R1 dout", int'(dout), 0);
    chk("R1 valid", int'(vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R7 valid", int'(vld), (k >= 3) ? 1 : 0);
    end
  endtask

  task automatic t_midscale;
    set3(0, 4, 2, 4); set3(1, 3, 6, 4); set3(2, 5, 0, 0); set3(3, 4, 0, 0);
    run(4, "R9 R3", 1'b0);
  endtask

  task automatic t_overflow;
    set3(0, 7, 6, 3); set3(1, 7, 6, 4); set3(2, 7, 7, 15);
    set3(3, 7, 7, 0); set3(4, 7, 5, 0);
    run(5, "R4", 1'b0);
  endtask

  task automatic t_underflow;
    set3(0, 0, 2, 3); set3(1, 0, 2, 4); set3(2, 0, 2, 5);
    set3(3, 0, 0, 0); set3(4, 0, 0, 15);
    run(5, "R5", 1'b0);
  endtask

  task automatic t_stream;
    for (int k = 0; k < 48; k++)
      set3(k, int'($urandom_range(7)), int'($urandom_range(7)), int'($urandom_range(15)));
    run(48, "R2 R3 R6", 1'b0);
  endtask

  task automatic t_oe;
    for (int k = 0; k < 12; k++)
      set3(k, int'($urandom_range(7)), int'($urandom_range(7)), int'($urandom_range(15)));
    run(12, "R8 data", 1'b1);
  endtask

  task automatic t_async_reset;
    set3(0, 6, 6, 6); set3(1, 6, 6, 6); set3(2, 6, 6, 6); set3(3, 6, 6, 6);
    run(4, "R6", 1'b0);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R1 async dout", int'(dout), 0);
    chk("R1 async valid", int'(vld), 0);
    @(negedge clk);
    chk("R1 held dout", int'(dout), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R7 refill", int'(vld), (k == 3) ? 1 : 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; s1 = '0; s2 = '0; s3 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset_fill();
    t_midscale();
    t_overflow();
    t_underflow();
    t_stream();
    t_oe();
    t_async_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule